// File: doc/BRIEF.md
# Streaming Descriptor CRC-32 Engine

This block computes a 32-bit cyclic redundancy check over a byte stream, one byte per clock. It is meant to sit on the path where command descriptor blocks pass between a host and an accelerator. On the sending side it generates the check value. On the receiving side it also compares the result against the value carried in the block.

Bytes arrive on a valid/data interface that has a start marker and an end marker. A byte accepted with the start marker first reloads the register, with either the fixed start value or a seed supplied by the caller, and is then folded in. So a new frame may follow the previous one with no idle cycle. The checksum uses the generator x^32 + x^29 + x^18 + x^14 + x^3 + 1 (0x20044009), processed most significant bit first. Neither the data nor the result is bit-reversed, and no final inversion is applied. One clock after the end byte is accepted, the engine raises a one-cycle done pulse and presents the result. In compare mode it also sets a sticky mismatch flag.

Top module: `dcb_crc32`

## Requirements
- R1: Each accepted byte updates the register as follows. The byte is XORed into the register's top eight bits. The register is then shifted left eight times, one bit at a time, and after each shift 0x20044009 is XORed in whenever the bit shifted out was 1.
- R2: Unless a seed is selected, a frame starts from 0xFFFFFFFF. The bytes 0x01, 0x02, 0x03, 0x04 give the result 0xF33CB7D3, with no bit reversal and no final XOR.
- R3: When `seed_use` is 1 on the start byte, `seed_val` replaces 0xFFFFFFFF as the start value of that frame.
- R4: A byte with `in_first`=1 restarts the computation even if the previous frame ended in the cycle just before, so frames may run back to back.
- R5: `crc_done` is 1 for exactly the one clock that follows the acceptance of a byte with `in_last`=1, and it is 0 in every other cycle. In that cycle `crc_out` holds the frame's result.
- R6: When `in_valid` is 0, the inputs have no effect. `crc_out` and `crc_err` keep their values.
- R7: When the end byte is accepted with `cmp_en`=1, `crc_err` becomes 1 if the frame's result differs from `cmp_expect`, and 0 if it matches. When the end byte is accepted with `cmp_en`=0, `crc_err` becomes 0.
- R8: `crc_err` keeps its value until the next end byte, or until a start byte without `in_last`, which clears it.
- R9: While reset is active, `crc_out` reads 0xFFFFFFFF and both `crc_done` and `crc_err` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Byte on `in_data` is accepted this cycle |
| in_data | input | 8 | Data byte |
| in_first | input | 1 | Accepted byte opens a frame |
| in_last | input | 1 | Accepted byte closes a frame |
| seed_use | input | 1 | Take `seed_val` as the start value (sampled with the start byte) |
| seed_val | input | 32 | Caller-supplied start value |
| cmp_en | input | 1 | Compare the result (sampled with the end byte) |
| cmp_expect | input | 32 | Expected result for compare mode |
| crc_out | output | 32 | Current checksum register |
| crc_done | output | 1 | One-cycle pulse: result of a completed frame |
| crc_err | output | 1 | Sticky compare mismatch flag |

## Verification
Any error in the register after a byte shows up on `crc_out` on the next clock, because the output is the register itself. So one wrong fold step, a missed seed, or a missed restart is visible within one cycle of the byte that caused it. A wrong flag state shows on `crc_err` in the cycle after the end byte, and it then persists, so it stays visible until the next frame. The bench predicts all three outputs every clock from its own byte-table model and compares them, with targeted checks on the known four-byte vector, seeding, back-to-back frames and the flag's hold behaviour.

// File: rtl/dcb_crc_pkg.sv
package dcb_crc_pkg;
   localparam int unsigned        CRC_WIDTH  = 32;
   localparam int unsigned        BYTE_WIDTH = 8;
   localparam logic [31:0]        GEN_POLY   = 32'h2004_4009;
   localparam logic [31:0]        START_VAL  = 32'hFFFF_FFFF;

   typedef struct packed {
      logic accept;
      logic open_f;
      logic close_f;
   } frame_ctl_t;
endpackage

// File: rtl/dcb_crc_fold.sv
module dcb_crc_fold #(
   parameter int unsigned     CW   = 32,
   parameter int unsigned     DW   = 8,
   parameter logic [CW-1:0]   POLY = '0
) (
   input  logic [CW-1:0] base_i,
   input  logic [DW-1:0] data_i,
   output logic [CW-1:0] next_o
);
   logic [CW-1:0] stage [DW+1];

   assign stage[0] = base_i;

   for (genvar g = 0; g < DW; g++) begin : g_bit
      logic fb;
      assign fb           = stage[g][CW-1] ^ data_i[DW-1-g];
      assign stage[g+1]   = {stage[g][CW-2:0], 1'b0} ^ (fb ? POLY : '0);
   end

   assign next_o = stage[DW];
endmodule

// File: rtl/dcb_crc_state.sv
module dcb_crc_state
   import dcb_crc_pkg::*;
#(
   parameter int unsigned     CW   = 32,
   parameter int unsigned     DW   = 8,
   parameter logic [CW-1:0]   POLY = '0,
   parameter logic [CW-1:0]   INIT = '1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  frame_ctl_t    ctl_i,
   input  logic [DW-1:0] data_i,
   input  logic          seed_use_i,
   input  logic [CW-1:0] seed_i,
   output logic [CW-1:0] crc_q_o,
   output logic [CW-1:0] crc_next_o
);
   logic [CW-1:0] crc_q;
   logic [CW-1:0] base;

   always_comb begin
      if (ctl_i.open_f) base = seed_use_i ? seed_i : INIT;
      else              base = crc_q;
   end

   dcb_crc_fold #(.CW(CW), .DW(DW), .POLY(POLY)) u_fold (
      .base_i (base),
      .data_i (data_i),
      .next_o (crc_next_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            crc_q <= INIT;
      else if (ctl_i.accept) crc_q <= crc_next_o;
   end

   assign crc_q_o = crc_q;
endmodule

// File: rtl/dcb_crc_result.sv
module dcb_crc_result
   import dcb_crc_pkg::*;
#(
   parameter int unsigned CW      = 32,
   parameter bit          HAS_CMP = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  frame_ctl_t    ctl_i,
   input  logic          cmp_en_i,
   input  logic [CW-1:0] expect_i,
   input  logic [CW-1:0] crc_next_i,
   output logic          done_o,
   output logic          err_o
);
   logic done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done_q <= 1'b0;
      else        done_q <= ctl_i.accept & ctl_i.close_f;
   end
   assign done_o = done_q;

   if (HAS_CMP) begin : g_cmp
      logic err_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) err_q <= 1'b0;
         else if (ctl_i.accept) begin
            if (ctl_i.close_f)     err_q <= cmp_en_i & (crc_next_i != expect_i);
            else if (ctl_i.open_f) err_q <= 1'b0;
         end
      end
      assign err_o = err_q;
   end else begin : g_nocmp
      logic unused_cmp;
      assign unused_cmp = cmp_en_i ^ (^expect_i);
      assign err_o      = 1'b0;
   end
endmodule

// File: rtl/dcb_crc32.sv
module dcb_crc32
   import dcb_crc_pkg::*;
#(
   parameter int unsigned     CW      = CRC_WIDTH,
   parameter int unsigned     DW      = BYTE_WIDTH,
   parameter logic [CW-1:0]   POLY    = GEN_POLY,
   parameter logic [CW-1:0]   INIT    = START_VAL,
   parameter bit              HAS_CMP = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [DW-1:0] in_data,
   input  logic          in_first,
   input  logic          in_last,
   input  logic          seed_use,
   input  logic [CW-1:0] seed_val,
   input  logic          cmp_en,
   input  logic [CW-1:0] cmp_expect,
   output logic [CW-1:0] crc_out,
   output logic          crc_done,
   output logic          crc_err
);
   if (DW < 1 || DW > CW) begin : g_bad_width
      $error("dcb_crc32: DW must lie in 1..CW");
   end
   if (POLY[0] != 1'b1) begin : g_bad_poly
      $error("dcb_crc32: generator must have its constant term set");
   end

   frame_ctl_t    ctl;
   logic [CW-1:0] crc_next;

   assign ctl.accept  = in_valid;
   assign ctl.open_f  = in_valid & in_first;
   assign ctl.close_f = in_valid & in_last;

   dcb_crc_state #(.CW(CW), .DW(DW), .POLY(POLY), .INIT(INIT)) u_state (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl_i      (ctl),
      .data_i     (in_data),
      .seed_use_i (seed_use),
      .seed_i     (seed_val),
      .crc_q_o    (crc_out),
      .crc_next_o (crc_next)
   );

   dcb_crc_result #(.CW(CW), .HAS_CMP(HAS_CMP)) u_result (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl_i      (ctl),
      .cmp_en_i   (cmp_en),
      .expect_i   (cmp_expect),
      .crc_next_i (crc_next),
      .done_o     (crc_done),
      .err_o      (crc_err)
   );
endmodule

// File: rtl/dcb_crc32_chk.sv
module dcb_crc32_chk #(
   parameter int unsigned CW = 32,
   parameter int unsigned DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic          in_first,
   input logic          in_last,
   input logic          cmp_en,
   input logic [CW-1:0] cmp_expect,
   input logic [CW-1:0] crc_out,
   input logic          crc_done,
   input logic          crc_err
);
   assert_done_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_last) |=> crc_done);

   assert_done_only_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && in_last) |=> !crc_done);

   assert_idle_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(crc_out) && $stable(crc_err)));

   assert_compare_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_last && cmp_en) |=> (crc_err == (crc_out != $past(cmp_expect))));

   assert_no_compare_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_last && !cmp_en) |=> !crc_err);

   assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_first && !in_last) |=> !crc_err);

   assert_mid_byte_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_first && !in_last) |=> $stable(crc_err));
endmodule

bind dcb_crc32 dcb_crc32_chk #(.CW(CW), .DW(DW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_first   (in_first),
   .in_last    (in_last),
   .cmp_en     (cmp_en),
   .cmp_expect (cmp_expect),
   .crc_out    (crc_out),
   .crc_done   (crc_done),
   .crc_err    (crc_err)
);

// File: tb/dcb_crc32_bench.sv
module dcb_crc32_bench;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] P = 32'h2004_4009;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_data = '0;
   logic        in_first = 1'b0;
   logic        in_last = 1'b0;
   logic        seed_use = 1'b0;
   logic [31:0] seed_val = '0;
   logic        cmp_en = 1'b0;
   logic [31:0] cmp_expect = '0;
   logic [31:0] crc_out;
   logic        crc_done;
   logic        crc_err;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dcb_crc32 u_dcb_crc32 (.*);

   function automatic logic [31:0] tab_entry(input logic [7:0] idx);
      logic [31:0] t;
      t = {idx, 24'h0};
      for (int k = 0; k < 8; k++) t = t[31] ? ((t << 1) ^ P) : (t << 1);
      return t;
   endfunction

   function automatic logic [31:0] step(input logic [31:0] c, input logic [7:0] d);
      return (c << 8) ^ tab_entry(c[31:24] ^ d);
   endfunction

   // behavioural reference, updated on every clock
   logic [31:0] m_crc = 32'hFFFF_FFFF;
   logic        m_done = 1'b0;
   logic        m_err = 1'b0;

   always @(posedge clk) begin
      logic [31:0] b, n;
      if (!rst_n) begin
         m_crc = 32'hFFFF_FFFF; m_done = 1'b0; m_err = 1'b0;
      end else begin
         m_done = in_valid && in_last;
         if (in_valid) begin
            b = in_first ? (seed_use ? seed_val : 32'hFFFF_FFFF) : m_crc;
            n = step(b, in_data);
            if (in_last)       m_err = cmp_en && (n != cmp_expect);
            else if (in_first) m_err = 1'b0;
            m_crc = n;
         end
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%08h expected=%08h at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check(crc_out == m_crc, "R1 crc_out", crc_out, m_crc);
         check(crc_done == m_done, "R5 crc_done", {31'b0, crc_done}, {31'b0, m_done});
         check(crc_err == m_err, "R7 crc_err", {31'b0, crc_err}, {31'b0, m_err});
      end
   end

   task automatic put(input logic [7:0] d, input bit f, input bit l);
      in_valid = 1'b1; in_data = d; in_first = f; in_last = l;
      @(posedge clk); @(negedge clk);
      in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog: actual=%08h expected=%08h", 0, 1);
         summary();
      end
   end

   initial begin
      logic [31:0] exp, held;
      repeat (3) @(negedge clk);
      // R9 reset state
      check(crc_out == 32'hFFFF_FFFF, "R9 reset crc", crc_out, 32'hFFFF_FFFF);
      check(!crc_done && !crc_err, "R9 reset flags", {30'b0, crc_done, crc_err}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 known vector
      put(8'h01, 1, 0); put(8'h02, 0, 0); put(8'h03, 0, 0); put(8'h04, 0, 1);
      check(crc_done, "R5 done after last", {31'b0, crc_done}, 1);
      check(crc_out == 32'hF33C_B7D3, "R2 vector", crc_out, 32'hF33C_B7D3);
      @(negedge clk);
      check(!crc_done, "R5 single pulse", {31'b0, crc_done}, 0);

      // R1 single zero byte from default start
      put(8'h00, 1, 1);
      exp = step(32'hFFFF_FFFF, 8'h00);
      check(crc_out == exp, "R1 single byte", crc_out, exp);

      // R6 idle inputs ignored
      held = crc_out;
      in_data = 8'hA5; in_first = 1'b1; in_last = 1'b1; seed_use = 1'b1; seed_val = 32'h0;
      repeat (3) @(negedge clk);
      in_first = 1'b0; in_last = 1'b0; seed_use = 1'b0;
      check(crc_out == held, "R6 idle hold", crc_out, held);

      // R3 seeded frame
      seed_use = 1'b1; seed_val = 32'h1234_5678;
      put(8'hDE, 1, 0);
      seed_use = 1'b0;
      put(8'hAD, 0, 1);
      exp = step(step(32'h1234_5678, 8'hDE), 8'hAD);
      check(crc_out == exp, "R3 seed", crc_out, exp);

      // R4 back to back frames
      put(8'h11, 1, 0); put(8'h22, 0, 1); put(8'h33, 1, 0); put(8'h44, 0, 1);
      exp = step(step(32'hFFFF_FFFF, 8'h33), 8'h44);
      check(crc_out == exp, "R4 back to back", crc_out, exp);

      // R7 compare match, then mismatch
      cmp_en = 1'b1; cmp_expect = 32'hF33C_B7D3;
      put(8'h01, 1, 0); put(8'h02, 0, 0); put(8'h03, 0, 0); put(8'h04, 0, 1);
      check(!crc_err, "R7 match", {31'b0, crc_err}, 0);
      cmp_expect = 32'hF33C_B7D2;
      put(8'h01, 1, 0); put(8'h02, 0, 0); put(8'h03, 0, 0); put(8'h04, 0, 1);
      check(crc_err, "R7 mismatch", {31'b0, crc_err}, 1);
      cmp_en = 1'b0;

      // R8 flag held through idle and middle bytes, cleared by start
      repeat (4) @(negedge clk);
      put(8'h55, 0, 0);
      check(crc_err, "R8 held", {31'b0, crc_err}, 1);
      put(8'h66, 1, 0);
      check(!crc_err, "R8 cleared by start", {31'b0, crc_err}, 0);
      put(8'h77, 0, 1);
      check(!crc_err, "R7 compare off", {31'b0, crc_err}, 0);

      // random frames, gaps, seeds and compares, checked each cycle
      for (int fr = 0; fr < 300; fr++) begin
         int len;
         len = 1 + ($urandom % 12);
         for (int i = 0; i < len; i++) begin
            while (($urandom % 4) == 0) @(negedge clk);
            seed_use   = $urandom % 2;
            seed_val   = $urandom;
            cmp_en     = $urandom % 2;
            cmp_expect = ($urandom % 2) ? m_crc : $urandom;
            put($urandom, i == 0, i == len - 1);
         end
      end

      finished = 1'b1;
      summary();
   end
endmodule